// File: doc/BRIEF.md
# Restart Opcode Responder for Shared Interrupt Line

This block sits between up to eight peripheral request lines and the single maskable interrupt input of a small processor. It combines the enabled requests into one interrupt line. During the processor's acknowledge cycle it answers on the data bus with a one-byte restart instruction. That instruction tells the processor which service entry to jump to. The vector address is eight times the index of the chosen line.

A fixed priority picks one line when several ask at once. The choice is captured when the active-low acknowledge strobe falls. It stays fixed until the strobe rises, so requests that change in the middle of the cycle cannot disturb the byte on the bus. When the strobe rises, the served peripheral gets a single-cycle clear pulse so that it withdraws its request. While that line is in service it no longer holds the interrupt line up, so the line drops unless another request is still waiting. The bus output comes with its own output-enable for the pad tri-state driver.

Top module: `rst_opcode_gen`

## Requirements
- R1: The byte driven during acknowledge has the form 11nnn111 (bits 7:6 and 2:0 all ones, bits 5:3 the winning line index n), so line 5 yields 8'hEF and the target address is 8*n.
- R2: When several enabled requests are active, the highest-numbered line wins; line 7 outranks all others and line 0 is lowest.
- R3: `intr_o` is high one clock after any line has both `req_i[k]` and `req_en_i[k]` high, and low one clock after none does; a request whose enable bit is 0 has no effect on `intr_o` or on the bus byte.
- R4: `data_oe_o` is high exactly while `inta_n_i` is low, and `data_o` reads 8'h00 whenever `inta_n_i` is high.
- R5: The winner is taken on the clock where `inta_n_i` is first seen low and the bus byte stays unchanged until `inta_n_i` returns high, whatever the requests do meanwhile.
- R6: After the first clock edge at which `inta_n_i` is seen high again, `clr_o` carries a one-hot pulse on the served line for exactly one cycle.
- R7: From the start of acknowledge until the clear pulse has ended, the served line is excluded from `intr_o`, so `intr_o` falls if no other enabled request is active and stays high if one is.
- R8: An acknowledge with no enabled request active drives 8'hFF and produces no clear pulse.
- R9: After reset `intr_o` is low, `clr_o` is all zeros and, with `inta_n_i` high, `data_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Peripheral request lines, bit k is line k |
| req_en_i | input | 8 | Per-line enable, bit k gates line k |
| inta_n_i | input | 1 | Active-low acknowledge strobe from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Restart byte for the data bus |
| data_oe_o | output | 1 | Tri-state enable for the data bus pads |
| clr_o | output | 8 | One-cycle clear pulse to the served peripheral |

## Verification
The bus byte and its enable follow the strobe combinationally, so they are checked one nanosecond after the strobe moves, before any clock edge. `intr_o` is registered, so it is sampled at the falling clock edge after the rising edge that saw the request; this also applies to the masking of the served line. The clear pulse appears after the first rising edge that sees the strobe high. The bench checks it at the next falling edge and checks that it is gone one cycle later. Frozen-byte checks change the requests after the first edge of the acknowledge window and sample the bus again one full cycle later.

// File: rtl/rst_opgen_pkg.sv
package rst_opgen_pkg;

    localparam int OPC_W       = 8;
    localparam int IDX_FIELD_W = 3;

    typedef logic [OPC_W-1:0]       opcode_t;
    typedef logic [IDX_FIELD_W-1:0] line_idx_t;

    // A winning line together with whether anything was requesting at all.
    typedef struct packed {
        logic      valid;
        line_idx_t idx;
    } grant_t;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_OPEN  = 2'd1,
        ACK_CLEAR = 2'd2
    } ack_state_e;

    localparam opcode_t   NO_REQ_BYTE = 8'hFF;
    localparam line_idx_t NO_REQ_IDX  = 3'd7;

    // Restart instruction: fixed ones around the 3-bit line index.
    function automatic opcode_t make_restart(line_idx_t idx);
        return {2'b11, idx, 3'b111};
    endfunction

endpackage

// File: rtl/rst_prio_enc.sv
module rst_prio_enc
    import rst_opgen_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] req_en_i,
    output logic [NUM_LINES-1:0] active_o,
    output grant_t               grant_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_gate
            assign active_o[g] = req_i[g] & req_en_i[g];
        end
    endgenerate

    // Ascending scan: the last active line found, i.e. the highest, wins.
    always_comb begin
        grant_o.valid = 1'b0;
        grant_o.idx   = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (active_o[i]) begin
                grant_o.valid = 1'b1;
                grant_o.idx   = i[IDX_FIELD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rst_ack_ctrl.sv
module rst_ack_ctrl
    import rst_opgen_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inta_n_i,
    input  grant_t               live_grant_i,
    output grant_t               bus_grant_o,
    output logic                 bus_oe_o,
    output logic [NUM_LINES-1:0] serve_mask_o,
    output logic [NUM_LINES-1:0] clr_o
);

    function automatic logic [NUM_LINES-1:0] to_onehot(grant_t g);
        logic [NUM_LINES-1:0] v;
        v = '0;
        if (g.valid) v[g.idx] = 1'b1;
        return v;
    endfunction

    logic       inta_q;
    logic       strobe_fall;
    logic       strobe_rise;
    ack_state_e state_q, state_d;
    grant_t     held_q;

    assign strobe_fall = inta_q & ~inta_n_i;
    assign strobe_rise = ~inta_q & inta_n_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:  if (strobe_fall) state_d = ACK_OPEN;
            ACK_OPEN:  if (strobe_rise) state_d = held_q.valid ? ACK_CLEAR : ACK_IDLE;
            ACK_CLEAR: state_d = strobe_fall ? ACK_OPEN : ACK_IDLE;
            default:   state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inta_q  <= 1'b1;
            state_q <= ACK_IDLE;
            held_q  <= '0;
        end else begin
            inta_q  <= inta_n_i;
            state_q <= state_d;
            if (strobe_fall) held_q <= live_grant_i;
        end
    end

    // On the first cycle of the window the capture is not registered yet.
    assign bus_grant_o = strobe_fall ? live_grant_i : held_q;
    assign bus_oe_o    = ~inta_n_i;

    always_comb begin
        if (strobe_fall)
            serve_mask_o = to_onehot(live_grant_i);
        else if (state_q != ACK_IDLE)
            serve_mask_o = to_onehot(held_q);
        else
            serve_mask_o = '0;
    end

    assign clr_o = (state_q == ACK_CLEAR) ? to_onehot(held_q) : '0;

endmodule

// File: rtl/rst_bus_drive.sv
module rst_bus_drive
    import rst_opgen_pkg::*;
(
    input  grant_t  grant_i,
    input  logic    oe_i,
    output opcode_t data_o
);

    always_comb begin
        if (!oe_i)
            data_o = '0;
        else if (grant_i.valid)
            data_o = make_restart(grant_i.idx);
        else
            data_o = NO_REQ_BYTE;
    end

endmodule

// File: rtl/rst_intr_gen.sv
module rst_intr_gen #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] active_i,
    input  logic [NUM_LINES-1:0] serve_mask_i,
    output logic                 intr_o
);

    logic intr_q;

    always_ff @(posedge clk) begin
        if (rst) intr_q <= 1'b0;
        else     intr_q <= |(active_i & ~serve_mask_i);
    end

    assign intr_o = intr_q;

endmodule

// File: rtl/rst_opcode_gen.sv
module rst_opcode_gen
    import rst_opgen_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] req_en_i,
    input  logic                 inta_n_i,
    output logic                 intr_o,
    output logic [OPC_W-1:0]     data_o,
    output logic                 data_oe_o,
    output logic [NUM_LINES-1:0] clr_o
);

    logic [NUM_LINES-1:0] active;
    logic [NUM_LINES-1:0] serve_mask;
    grant_t               live_grant;
    grant_t               bus_grant;

    rst_prio_enc #(.NUM_LINES(NUM_LINES)) enc_i (
        .req_i    (req_i),
        .req_en_i (req_en_i),
        .active_o (active),
        .grant_o  (live_grant)
    );

    rst_ack_ctrl #(.NUM_LINES(NUM_LINES)) ack_i (
        .clk          (clk),
        .rst          (rst),
        .inta_n_i     (inta_n_i),
        .live_grant_i (live_grant),
        .bus_grant_o  (bus_grant),
        .bus_oe_o     (data_oe_o),
        .serve_mask_o (serve_mask),
        .clr_o        (clr_o)
    );

    rst_bus_drive bus_i (
        .grant_i (bus_grant),
        .oe_i    (data_oe_o),
        .data_o  (data_o)
    );

    rst_intr_gen #(.NUM_LINES(NUM_LINES)) intr_i (
        .clk          (clk),
        .rst          (rst),
        .active_i     (active),
        .serve_mask_i (serve_mask),
        .intr_o       (intr_o)
    );

endmodule

// File: rtl/rst_opcode_gen_chk.sv
module rst_opcode_gen_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] req_i,
    input logic [NUM_LINES-1:0] req_en_i,
    input logic                 inta_n_i,
    input logic                 intr_o,
    input logic [7:0]           data_o,
    input logic                 data_oe_o,
    input logic [NUM_LINES-1:0] clr_o
);

    assert_opcode_shape_R1: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (data_o[7:6] == 2'b11 && data_o[2:0] == 3'b111));

    assert_intr_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(|(req_i & req_en_i)) |-> !intr_o);

    assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        inta_n_i |-> (!data_oe_o && data_o == 8'h00));

    assert_byte_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (!inta_n_i && !$past(inta_n_i)) |-> $stable(data_o));

    assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_o));

    assert_clr_single_R6: assert property (@(posedge clk) disable iff (rst)
        (|clr_o) |=> (clr_o == '0));

    assert_clr_after_release_R6: assert property (@(posedge clk) disable iff (rst)
        (|clr_o) |-> $past(inta_n_i));

endmodule

bind rst_opcode_gen rst_opcode_gen_chk #(.NUM_LINES(NUM_LINES)) chk_i (.*);

// File: tb/rst_opcode_gen_tb.sv
module rst_opcode_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] req;
    logic [7:0] en;
    logic       inta_n;
    logic       intr;
    logic [7:0] data;
    logic       oe;
    logic [7:0] clr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rst_opcode_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .req_en_i  (en),
        .inta_n_i  (inta_n),
        .intr_o    (intr),
        .data_o    (data),
        .data_oe_o (oe),
        .clr_o     (clr)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One full request / acknowledge / release sequence.
    task automatic run_case(input logic [7:0] r, input logic [7:0] e);
        logic [7:0] act;
        logic [7:0] oh;
        logic [7:0] exp_byte;
        bit         any;
        int         win;
        act = r & e;
        any = (act != 8'h00);
        win = -1;
        for (int k = 7; k >= 0; k--) if (win < 0 && act[k]) win = k;
        oh       = any ? (8'h01 << win) : 8'h00;
        exp_byte = any ? (8'hC7 | (8'(win) << 3)) : 8'hFF;

        req = r; en = e;
        tick(); tick();
        check("R3 intr from enabled requests", {7'd0, intr}, {7'd0, any});

        inta_n = 1'b0;
        #1;
        check("R4 oe during acknowledge", {7'd0, oe}, 8'h01);
        check("R1/R2/R8 restart byte", data, exp_byte);
        tick();
        check("R7 served line masked from intr", {7'd0, intr}, {7'd0, |(act & ~oh)});
        req = ~r;
        tick();
        check("R5 byte frozen under changing requests", data, exp_byte);
        inta_n = 1'b1;
        req = r;
        #1;
        check("R4 oe after release", {7'd0, oe}, 8'h00);
        check("R4 bus zero after release", data, 8'h00);
        tick();
        check("R6/R8 clear pulse to served line", clr, oh);
        req = r & ~oh;
        tick();
        check("R6 clear pulse lasts one cycle", clr, 8'h00);
        check("R7 intr reflects remaining requests", {7'd0, intr}, {7'd0, |(act & ~oh)});
        req = 8'h00;
        tick(); tick();
    endtask

    initial begin
        rst = 1'b1; req = 8'h00; en = 8'hFF; inta_n = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R9 intr after reset", {7'd0, intr}, 8'h00);
        check("R9 clr after reset", clr, 8'h00);
        check("R9 oe after reset", {7'd0, oe}, 8'h00);

        // Every request pattern with all lines enabled.
        for (int p = 0; p < 256; p++) run_case(8'(p), 8'hFF);
        // Every enable pattern with all lines requesting, then a sparse pattern.
        for (int m = 0; m < 256; m++) run_case(8'hFF, 8'(m));
        for (int m = 0; m < 256; m++) run_case(8'hA5, 8'(m));
        // Line 5 alone must give the documented byte.
        run_case(8'h20, 8'hFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule